// File: doc/BRIEF.md
# Three-Wire Codec Control Master

This block drives the write-only control link of an audio codec. The link has three lines: a mode line, a clock line and a data line. A host hands the block one register-write command at a time over a valid/ready handshake. Each command names a target kind, a payload byte and, for extended targets, a 3-bit extended address. The block then plays out the whole sequence on the three lines without further help.

Each transfer starts with an address byte. The mode line is held low during that byte. One or two data bytes follow with the mode line high. Status, data0 and data1 writes send their own address and then the payload. Extended writes go through an escape: they send the data0 address, then a sub-address byte, then a value byte. All line timing is counted in system clocks by a single counter. One bit time is `BIT_CLKS` clocks, and each clock half lasts one bit time.

Top module: `tw_codec_master`

## Requirements
- R1: Out of reset, and whenever the block is not busy, the mode line and the clock line are both high, `busy` is 0 and `done` is 0.
- R2: A transfer begins with an address byte. The mode line goes low while the clock line stays high, and this lead-in lasts exactly `BIT_CLKS` cycles before the first bit.
- R3: Every byte is sent as 8 bits, bit 0 first and bit 7 last.
- R4: For each bit, the clock line is low for `BIT_CLKS` cycles and then high for `BIT_CLKS` cycles. The data line carries the bit value for that whole window and does not change while the clock line is high.
- R5: After the address byte, the mode line returns high. Each data byte is preceded by a `BIT_CLKS`-cycle lead-in with both the mode line and the clock line high.
- R6: Kind encoding is 0 = status, 1 = data0, 2 = data1. These kinds send the `ADDR_STATUS`, `ADDR_DATA0` or `ADDR_DATA1` parameter byte, then the payload byte, for 34·`BIT_CLKS` cycles in total.
- R7: Kind 3 (extended) sends three bytes, for 51·`BIT_CLKS` cycles in total. The first is `ADDR_DATA0`. The second is 8'hC0 OR the 3-bit extended address. The third is 8'hE0 OR the payload.
- R8: `cmd_ready` is high exactly when the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Any command input presented while busy has no effect on the lines.
- R9: `done` is a single-cycle pulse. It appears in the cycle after the last clock-high half ends, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_kind | input | 2 | 0 status, 1 data0, 2 data1, 3 extended |
| cmd_byte | input | 8 | Payload byte |
| cmd_ext | input | 3 | Extended register address (kind 3 only) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| ctl_mode | output | 1 | Mode line: low for address, high for data |
| ctl_clk | output | 1 | Link clock line |
| ctl_data | output | 1 | Link data line |

## Verification
The bound checker covers the per-cycle line rules on every cycle:
- both lines are high when idle;
- the mode line only changes while the clock line is high;
- the data line holds steady through each clock-high half;
- `done` is a lone pulse outside `busy`;
- a transfer only starts from an offered command.

Bit order, the exact lengths of the lead-ins and halves, the byte contents for each kind, and the extended escape bytes can only be shown by the bench. It compares every cycle of every transfer against a waveform computed from the command. The bench also covers commands held during a transfer: it shows they are ignored by sweeping payloads while `cmd_valid` stays high with altered inputs.

// File: rtl/tw_codec_master.sv
module tw_codec_master #(
  parameter int          BIT_CLKS    = 250,
  parameter logic [7:0]  ADDR_STATUS = 8'h16,
  parameter logic [7:0]  ADDR_DATA0  = 8'h14,
  parameter logic [7:0]  ADDR_DATA1  = 8'h15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_kind,
  input  logic [7:0] cmd_byte,
  input  logic [2:0] cmd_ext,
  output logic       busy,
  output logic       done,
  output logic       ctl_mode,
  output logic       ctl_clk,
  output logic       ctl_data
);
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_i;
  logic [1:0]    left;
  logic [7:0]    sr, nxt0, nxt1;
  logic [7:0]    addr_sel;

  wire take   = cmd_valid && cmd_ready;
  wire cnt_end = (cnt == '0);

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;

  always_comb begin
    case (cmd_kind)
      2'd0:    addr_sel = ADDR_STATUS;
      2'd2:    addr_sel = ADDR_DATA1;
      default: addr_sel = ADDR_DATA0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bit_i    <= '0;
      left     <= '0;
      sr       <= '0;
      nxt0     <= '0;
      nxt1     <= '0;
      done     <= 1'b0;
      ctl_mode <= 1'b1;
      ctl_clk  <= 1'b1;
      ctl_data <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          st       <= S_LEAD;
          cnt      <= CNT_LAST;
          bit_i    <= '0;
          sr       <= addr_sel;
          ctl_mode <= 1'b0;
          if (cmd_kind == 2'd3) begin
            nxt0 <= 8'hC0 | {5'b0, cmd_ext};
            nxt1 <= 8'hE0 | cmd_byte;
            left <= 2'd2;
          end else begin
            nxt0 <= cmd_byte;
            nxt1 <= '0;
            left <= 2'd1;
          end
        end
        S_LEAD: begin
          if (cnt_end) begin
            st       <= S_LOW;
            cnt      <= CNT_LAST;
            ctl_clk  <= 1'b0;
            ctl_data <= sr[0];
          end else cnt <= cnt - 1'b1;
        end
        S_LOW: begin
          if (cnt_end) begin
            st      <= S_HIGH;
            cnt     <= CNT_LAST;
            ctl_clk <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_HIGH: begin
          if (!cnt_end) cnt <= cnt - 1'b1;
          else if (bit_i != 3'd7) begin
            st       <= S_LOW;
            cnt      <= CNT_LAST;
            bit_i    <= bit_i + 1'b1;
            sr       <= sr >> 1;
            ctl_clk  <= 1'b0;
            ctl_data <= sr[1];
          end else if (left != 2'd0) begin
            st       <= S_LEAD;
            cnt      <= CNT_LAST;
            bit_i    <= '0;
            sr       <= nxt0;
            nxt0     <= nxt1;
            left     <= left - 1'b1;
            ctl_mode <= 1'b1;
          end else begin
            st       <= S_IDLE;
            done     <= 1'b1;
            ctl_mode <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tw_codec_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic ctl_mode,
  input logic ctl_clk,
  input logic ctl_data
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctl_mode && ctl_clk));
  // R2
  mode_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_mode) |-> ctl_clk);
  // R5
  mode_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_mode) |-> ctl_clk);
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clk && $past(ctl_clk) && busy && $past(busy)) |-> $stable(ctl_data));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
endmodule

bind tw_codec_master tw_codec_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .ctl_mode(ctl_mode), .ctl_clk(ctl_clk), .ctl_data(ctl_data)
);

// File: tb/tw_codec_master_tb_top.sv
module tw_codec_master_tb_top;
  localparam int BT = 3;
  localparam logic [7:0] A_ST = 8'h16, A_D0 = 8'h14, A_D1 = 8'h15;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_kind = 0;
  logic [7:0] cmd_byte = 0;
  logic [2:0] cmd_ext = 0;
  logic cmd_ready, busy, done, ctl_mode, ctl_clk, ctl_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tw_codec_master #(.BIT_CLKS(BT), .ADDR_STATUS(A_ST), .ADDR_DATA0(A_D0),
                    .ADDR_DATA1(A_D1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_byte(cmd_byte), .cmd_ext(cmd_ext), .busy(busy),
    .done(done), .ctl_mode(ctl_mode), .ctl_clk(ctl_clk), .ctl_data(ctl_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cmd(input int kind, input int val, input int ext, input bit hold);
    logic [7:0] b [3];
    int n, total;
    string dreq;
    if (kind == 3) begin
      b[0] = A_D0; b[1] = 8'hC0 | 8'(ext); b[2] = 8'hE0 | 8'(val); n = 3; dreq = "R3 R7";
    end else begin
      b[0] = (kind == 0) ? A_ST : (kind == 1) ? A_D0 : A_D1;
      b[1] = 8'(val); b[2] = 0; n = 2; dreq = "R3 R6";
    end
    total = 17 * BT * n;
    chk(cmd_ready == 1, "R8 ready idle", int'(cmd_ready), 1);
    cmd_valid = 1; cmd_kind = 2'(kind); cmd_byte = 8'(val); cmd_ext = 3'(ext);
    @(posedge clk);
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      if (k < total) begin
        int j = k / (17 * BT);
        int r = k % (17 * BT);
        int em = (j == 0) ? 0 : 1;
        chk(ctl_mode == em, (j == 0) ? "R2 mode" : "R5 mode", int'(ctl_mode), em);
        chk(busy == 1 && cmd_ready == 0, "R8 busy", int'(busy), 1);
        chk(done == 0, "R9 early done", int'(done), 0);
        if (r < BT) begin
          chk(ctl_clk == 1, (j == 0) ? "R2 lead clk" : "R5 lead clk", int'(ctl_clk), 1);
        end else begin
          int q = r - BT;
          int bi = q / (2 * BT);
          int ec = ((q % (2 * BT)) < BT) ? 0 : 1;
          chk(ctl_clk == ec, "R4 clk", int'(ctl_clk), ec);
          chk(ctl_data == b[j][bi], dreq, int'(ctl_data), int'(b[j][bi]));
        end
        if (k == 0) begin
          if (hold) begin
            cmd_kind = ~cmd_kind; cmd_byte = ~cmd_byte; cmd_ext = ~cmd_ext;
          end else cmd_valid = 0;
        end
        if (k == total - 3) cmd_valid = 0;
      end else begin
        chk(done == 1, "R9 done", int'(done), 1);
        chk(busy == 0, "R9 busy low", int'(busy), 0);
        chk(ctl_mode && ctl_clk, "R1 idle lines", int'({ctl_mode, ctl_clk}), 3);
      end
    end
    @(negedge clk);
    chk(done == 0, "R9 one cycle", int'(done), 0);
    chk(busy == 0 && ctl_mode && ctl_clk, "R1 idle", int'({busy, ctl_mode, ctl_clk}), 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctl_mode && ctl_clk && !busy && !done && cmd_ready, "R1 reset",
        int'({ctl_mode, ctl_clk, busy, done, cmd_ready}), 25);
    rst_n = 1;
    @(negedge clk);
    chk(ctl_mode && ctl_clk && !busy, "R1 after reset", int'({ctl_mode, ctl_clk, busy}), 6);
    for (int kind = 0; kind < 3; kind++)
      for (int v = 0; v < 256; v++)
        run_cmd(kind, v, 0, (v % 16) == 5);
    for (int e = 0; e < 8; e++)
      for (int v = 0; v < 32; v++)
        run_cmd(3, (v * 37 + e) % 256, e, (v % 8) == 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule